// File: doc/BRIEF.md
# Supply-Fail Supervisor with Reset Hold

This block watches a single supply-status bit from an external, already debounced comparator whose threshold is the write-protect trip point. The bit is synchronous to the block clock. While the supply is good the block passes the memory array's active-low chip-enable, write-enable and output-enable through unchanged. When the supply falls away, it blocks all three at once. Blocking output-enable leaves the data pins at high impedance. The block also requests a system reset by enabling a drive-low on an open-drain-style reset line.

When the supply comes back, two timed windows start from the same moment. The reset request is held for one window and the write protection for the other. Both lengths are parameters in clock cycles, so a bench can use scaled time. A new failure inside either window clears the timing and brings back protection and reset with no debounce delay. A two-bit phase output shows which phase the supervisor is in.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_pull_low` is 1, `wr_protect` is 1, `phase` is 2'b00 and all three gated memory controls are 1.
- R2: In any cycle where `supply_ok` is 0, `wr_protect` is 1 and `mem_ce_n_o`, `mem_we_n_o` and `mem_oe_n_o` are 1 in that same cycle, whatever the memory control inputs are.
- R3: When a rising clock edge samples `supply_ok` at 0, `rst_pull_low` is 1 and `phase` is 2'b00 from that edge onward, until the supply returns.
- R4: Count the consecutive rising edges that sample `supply_ok` at 1. `rst_pull_low` stays 1 while that count is at most RST_HOLD_CYC and drops to 0 once the count exceeds it.
- R5: With the same count, `wr_protect` stays 1 while the count is at most REC_CYC and drops to 0 once the count exceeds it, provided `supply_ok` is still 1.
- R6: While `wr_protect` is 0, each gated control output equals its input.
- R7: A supply failure during the reset-hold window or the recovery window clears the timing. On the next return both windows start again from zero, with no credit for time already counted.
- R8: `phase` is encoded as follows: 2'b00 failed (the count is 0); 2'b01 reset hold (the count is non-zero and reset is requested); 2'b10 recovery (reset released, write protection still timed); 2'b11 normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok | input | 1 | Debounced comparator status, 1 = supply above trip point |
| mem_ce_n_i | input | 1 | Chip-enable from the host, active low |
| mem_we_n_i | input | 1 | Write-enable from the host, active low |
| mem_oe_n_i | input | 1 | Output-enable from the host, active low |
| mem_ce_n_o | output | 1 | Gated chip-enable to the array |
| mem_we_n_o | output | 1 | Gated write-enable to the array |
| mem_oe_n_o | output | 1 | Gated output-enable to the array |
| rst_pull_low | output | 1 | Drive-low enable for the open-drain reset line |
| wr_protect | output | 1 | Write-protect flag |
| phase | output | 2 | Supervisor phase, encoded as in R8 |

## Verification
The bench builds the block with RST_HOLD_CYC = 12 and REC_CYC = 20, so the recovery window outlasts the reset window. This makes all four phases appear within a few dozen cycles. These small values let the bench drop the supply at chosen counts: early in the reset hold, inside the recovery-only stretch, and for a single cycle after normal operation is reached. Each restart can then be compared with a fresh window of the exact expected length.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    PH_FAILED  = 2'b00,
    PH_HOLD    = 2'b01,
    PH_RECOVER = 2'b10,
    PH_NORMAL  = 2'b11
  } supv_phase_e;

  localparam int unsigned N_CTRL = 3;
endpackage

// File: rtl/supv_timer.sv
// Counts cycles since the supply returned; clears at once on any failure.
module supv_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MAX_CNT = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  output logic             ok_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_CNT);

  logic             ok_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    ok_d   = supply_ok;
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!supply_ok || !ok_q) begin
      cnt_d = '0;
    end else if (cnt_q != SAT) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ok_q <= ok_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end
endmodule

// File: rtl/supv_phase.sv
// Decodes the two release windows and the phase from the timer state.
module supv_phase
  import supv_pkg::*;
#(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned RST_HOLD_CYC = 12,
  parameter int unsigned REC_CYC      = 20
) (
  input  logic             supply_ok,
  input  logic             ok_q,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             rst_req,
  output logic             wprot,
  output supv_phase_e      phase
);
  localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RST_HOLD_CYC);
  localparam logic [CNT_W-1:0] REC_LIM = CNT_W'(REC_CYC);

  logic rec_act;

  always_comb begin
    rst_req = !ok_q || (cnt_q < RST_LIM);
    rec_act = !ok_q || (cnt_q < REC_LIM);
    wprot   = rec_act || !supply_ok;
    if (!ok_q) begin
      phase = PH_FAILED;
    end else if (rst_req) begin
      phase = PH_HOLD;
    end else if (rec_act) begin
      phase = PH_RECOVER;
    end else begin
      phase = PH_NORMAL;
    end
  end
endmodule

// File: rtl/supv_gate.sv
// Forces each active-low control inactive while blocked.
module supv_gate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] in_n,
  input  logic         block,
  output logic [N-1:0] out_n
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign out_n[i] = in_n[i] | block;
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supv_pkg::*;
#(
  parameter int unsigned RST_HOLD_CYC = 6554,
  parameter int unsigned REC_CYC      = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       mem_ce_n_i,
  input  logic       mem_we_n_i,
  input  logic       mem_oe_n_i,
  output logic       mem_ce_n_o,
  output logic       mem_we_n_o,
  output logic       mem_oe_n_o,
  output logic       rst_pull_low,
  output logic       wr_protect,
  output logic [1:0] phase
);
  localparam int unsigned MAX_CNT = (RST_HOLD_CYC > REC_CYC) ? RST_HOLD_CYC : REC_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1) + 1;

  logic              ok_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wprot;
  supv_phase_e       ph;
  logic [N_CTRL-1:0] ctrl_in;
  logic [N_CTRL-1:0] ctrl_out;

  supv_timer #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) timer_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .ok_q(ok_q), .cnt_q(cnt_q)
  );

  supv_phase #(.CNT_W(CNT_W), .RST_HOLD_CYC(RST_HOLD_CYC), .REC_CYC(REC_CYC)) phase_i (
    .supply_ok(supply_ok), .ok_q(ok_q), .cnt_q(cnt_q),
    .rst_req(rst_pull_low), .wprot(wprot), .phase(ph)
  );

  assign ctrl_in = {mem_oe_n_i, mem_we_n_i, mem_ce_n_i};

  supv_gate #(.N(N_CTRL)) gate_i (
    .in_n(ctrl_in), .block(wprot), .out_n(ctrl_out)
  );

  assign mem_ce_n_o = ctrl_out[0];
  assign mem_we_n_o = ctrl_out[1];
  assign mem_oe_n_o = ctrl_out[2];
  assign wr_protect = wprot;
  assign phase      = ph;
endmodule

// File: rtl/supv_chk.sv
module supv_chk #(
  parameter int unsigned RST_HOLD_CYC = 6554,
  parameter int unsigned REC_CYC      = 4096
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       mem_ce_n_i,
  input logic       mem_we_n_i,
  input logic       mem_oe_n_i,
  input logic       mem_ce_n_o,
  input logic       mem_we_n_o,
  input logic       mem_oe_n_o,
  input logic       rst_pull_low,
  input logic       wr_protect,
  input logic [1:0] phase
);
  localparam int unsigned MAXC = (RST_HOLD_CYC > REC_CYC) ? RST_HOLD_CYC : REC_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 2) + 1;

  // Consecutive good-supply samples, saturating just past the longest window.
  logic [CW-1:0] ok_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_run <= '0;
    end else if (!supply_ok) begin
      ok_run <= '0;
    end else if (ok_run <= CW'(MAXC)) begin
      ok_run <= ok_run + 1'b1;
    end
  end

  AST_FAIL_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (wr_protect && mem_ce_n_o && mem_we_n_o && mem_oe_n_o)); // R2
  AST_FAIL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (rst_pull_low && phase == 2'b00)); // R3
  AST_RST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pull_low == (ok_run <= CW'(RST_HOLD_CYC))); // R4
  AST_WP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect == (!supply_ok || ok_run <= CW'(REC_CYC))); // R5
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_protect |-> (mem_ce_n_o == mem_ce_n_i && mem_we_n_o == mem_we_n_i
                     && mem_oe_n_o == mem_oe_n_i)); // R6
  AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |=> rst_pull_low); // R7
  AST_NORMAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 && supply_ok) |-> (!wr_protect && !rst_pull_low)); // R8
endmodule

bind supply_supervisor supv_chk #(.RST_HOLD_CYC(RST_HOLD_CYC), .REC_CYC(REC_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
  .mem_ce_n_i(mem_ce_n_i), .mem_we_n_i(mem_we_n_i), .mem_oe_n_i(mem_oe_n_i),
  .mem_ce_n_o(mem_ce_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
  .rst_pull_low(rst_pull_low), .wr_protect(wr_protect), .phase(phase)
);

// File: tb/supply_supervisor_tb_top.sv
module supply_supervisor_tb_top;
  localparam int RST_HOLD = 12;
  localparam int REC      = 20;
  localparam int MAXC     = (RST_HOLD > REC) ? RST_HOLD : REC;

  typedef struct {
    logic       rst;
    logic       wp;
    logic [2:0] outs;
    logic [1:0] ph;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic ce_i = 1'b1, we_i = 1'b1, oe_i = 1'b1;
  logic ce_o, we_o, oe_o, rst_o, wp_o;
  logic [1:0] ph_o;

  int checks = 0;
  int fails = 0;
  int run = 0;
  bit done = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  supply_supervisor #(.RST_HOLD_CYC(RST_HOLD), .REC_CYC(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .mem_ce_n_i(ce_i), .mem_we_n_i(we_i), .mem_oe_n_i(oe_i),
    .mem_ce_n_o(ce_o), .mem_we_n_o(we_o), .mem_oe_n_o(oe_o),
    .rst_pull_low(rst_o), .wr_protect(wp_o), .phase(ph_o)
  );

  // Reference count of consecutive good-supply edges, from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (!supply_ok) run <= 0;
    else if (run <= MAXC) run <= run + 1;
  end

  task automatic step(input logic ok, input logic [2:0] ctl, input string tag);
    exp_t e;
    @(negedge clk);
    supply_ok = ok;
    {oe_i, we_i, ce_i} = ctl;
    e.rst  = (run <= RST_HOLD);
    e.wp   = !ok || (run <= REC);
    e.outs = ctl | {3{e.wp}};
    e.ph   = (run == 0) ? 2'b00 : (run <= RST_HOLD) ? 2'b01 : (run <= REC) ? 2'b10 : 2'b11;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input string req, input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t act=%0h exp=%0h", req, tag, $time, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares with the ports.
  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp("R3/R4 rst_pull_low", rst_o, e.rst, e.tag);
      cmp("R2/R5 wr_protect", wp_o, e.wp, e.tag);
      cmp("R6/R2 gated controls", {oe_o, we_o, ce_o}, e.outs, e.tag);
      cmp("R8 phase", ph_o, e.ph, e.tag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, with supply good and host controls active.
    for (int i = 0; i < 3; i++) step(1'b1, 3'b000, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    // Return from reset with the supply still low.
    for (int i = 0; i < 3; i++) step(1'b0, 3'b000, "R2 fail gating");
    // Full power-up: hold, recovery, normal, with varied controls.
    for (int i = 0; i < 26; i++) step(1'b1, 3'(i), "R4/R5 power-up");
    for (int i = 0; i < 8; i++) step(1'b1, 3'(7 - i), "R6 pass-through");
    // Failure while in normal operation.
    for (int i = 0; i < 3; i++) step(1'b0, 3'b010, "R2/R3 fail");
    // R7: failure early in the reset hold.
    for (int i = 0; i < 6; i++) step(1'b1, 3'b001, "R7 hold");
    step(1'b0, 3'b000, "R7 drop in hold");
    // R7: failure during the recovery-only stretch.
    for (int i = 0; i < 16; i++) step(1'b1, 3'b100, "R7 recover");
    step(1'b0, 3'b000, "R7 drop in recovery");
    for (int i = 0; i < 25; i++) step(1'b1, 3'b101, "R7 fresh windows");
    // Single-cycle dip after normal operation.
    step(1'b0, 3'b000, "R2 dip");
    for (int i = 0; i < 24; i++) step(1'b1, 3'b011, "R8 after dip");
    repeat (3) @(negedge clk);
    #3;
    finish_run();
  end
endmodule